// File: doc/BRIEF.md
# Nonvolatile Commit and Recall Sequencer

This block owns an 8-bit volatile DAC setting and keeps a copy of it in one byte of nonvolatile storage. When reset is released, it copies the stored byte into the volatile setting before it accepts any request. From then on the setting can be rewritten freely through a simple write strobe.

A commit request copies the present setting into storage. The commit first erases the cell with a timed pulse and reads it back. Erase is repeated until the cell reads as erased, with at most four pulses. The same pulse-and-verify loop then writes the captured value. A request is accepted only when the write-enable input and the programming-supply-good input are both high. Once a commit has started, the write-enable input no longer matters.

A busy output covers the whole commit. An error flag reports a refused request (supply low) or a phase that still fails to verify after its last pulse. Pulse widths are parameters, and the worst case of eight pulses fits inside a cycle budget that is also a parameter.

Top module: `nv_commit_seq`

## Requirements
- R1: After reset is released, `ready` is low for exactly one cycle. At the first rising edge `dac_val` takes the value on `cell_rdata` and `ready` goes high; no write or commit is accepted before that edge.
- R2: While idle and ready, `wr_en` with `wp_ok` high loads `wr_data` into `dac_val` at the next edge. With `wp_ok` low, `wr_en` leaves `dac_val` unchanged.
- R3: `commit_req` with `wp_ok` low is ignored: no pulse is issued, `busy` stays low and `err` does not change.
- R4: `commit_req` with `wp_ok` high and `supply_ok` low issues no pulse, keeps `busy` low and sets `err` at the next edge.
- R5: An accepted commit raises `busy` at the next edge and holds it until the sequence ends. While `busy` is high, `commit_req` and `wr_en` are ignored, `dac_val` is held, and `wp_ok` going low does not abort the commit.
- R6: Each erase pulse holds `cell_erase` high for `ERASE_CYC` cycles. The next cycle reads `cell_rdata`, and an all-ones value (8'hFF) counts as erased. An erase pulse is repeated until the cell reads as erased, up to 4 pulses in total.
- R7: After a good erase, each write pulse holds `cell_write` high for `WRITE_CYC` cycles, with `cell_wdata` equal to the `dac_val` captured at acceptance. A write pulse is repeated until `cell_rdata` matches that value, up to 4 pulses in total.
- R8: If either phase still fails after its 4th pulse, the sequence issues no further pulses, sets `err`, and returns to idle with `busy` low.
- R9: `cell_erase` and `cell_write` are never high together, and neither is high unless `busy` is high.
- R10: `busy` never stays high for more than `BUDGET_CYC` consecutive cycles.
- R11: If `commit_req` and `wr_en` are both presented in the same idle cycle, the commit wins. The write is dropped and the committed value is the setting held before that cycle.
- R12: An accepted commit clears `err`, so a commit that completes leaves `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Volatile setting write strobe |
| wr_data | input | 8 | Value for the volatile setting |
| commit_req | input | 1 | Request to store the setting in the nonvolatile cell |
| wp_ok | input | 1 | High allows writes and commits |
| supply_ok | input | 1 | Programming supply is above its threshold |
| cell_rdata | input | 8 | Present content of the nonvolatile cell |
| cell_erase | output | 1 | Erase pulse to the cell |
| cell_write | output | 1 | Write pulse to the cell |
| cell_wdata | output | 8 | Value applied during a write pulse |
| dac_val | output | 8 | Volatile DAC setting |
| busy | output | 1 | Commit in progress |
| err | output | 1 | Last request refused or last commit failed |
| ready | output | 1 | Power-up recall has completed |

## Verification
A commit request and a volatile write can land in the same idle cycle, and the block must decide which one wins. The bench sets the setting to one value. In a single cycle it then raises both `commit_req` and `wr_en` carrying a different value. It judges the result after the commit completes: the stored cell byte and `dac_val` must both equal the earlier value, and the cell-write data must never have shown the dropped one. A second overlap, requests and writes arriving while `busy` is high together with `wp_ok` dropping, is judged the same way on the stored byte.

// File: rtl/nv_commit_seq.sv
module nv_commit_seq #(
  parameter int W          = 8,
  parameter int ERASE_CYC  = 16,
  parameter int WRITE_CYC  = 16,
  parameter int MAX_TRIES  = 4,
  parameter int BUDGET_CYC = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit_req,
  input  logic         wp_ok,
  input  logic         supply_ok,
  input  logic [W-1:0] cell_rdata,
  output logic         cell_erase,
  output logic         cell_write,
  output logic [W-1:0] cell_wdata,
  output logic [W-1:0] dac_val,
  output logic         busy,
  output logic         err,
  output logic         ready
);
  localparam int MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TW   = $clog2(MAX_TRIES + 1);
  localparam int BW   = $clog2(BUDGET_CYC + 2);
  localparam logic [W-1:0] ERASED = {W{1'b1}};

  typedef enum logic [2:0] {S_RECALL, S_IDLE, S_ERASE, S_CHK_E, S_WRITE, S_CHK_W} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic [W-1:0]  tgt;

  wire accept   = (st == S_IDLE) && commit_req && wp_ok;
  wire last_try = (tries == TW'(MAX_TRIES - 1));

  assign cell_erase = (st == S_ERASE);
  assign cell_write = (st == S_WRITE);
  assign cell_wdata = tgt;
  assign busy       = (st != S_IDLE) && (st != S_RECALL);
  assign ready      = (st != S_RECALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RECALL;
      dac_val <= '0;
      tgt   <= '0;
      cnt   <= '0;
      tries <= '0;
      err   <= 1'b0;
    end else begin
      case (st)
        S_RECALL: begin
          dac_val <= cell_rdata;
          st      <= S_IDLE;
        end
        S_IDLE: begin
          if (accept) begin
            if (supply_ok) begin
              tgt   <= dac_val;
              err   <= 1'b0;
              tries <= '0;
              cnt   <= CW'(ERASE_CYC - 1);
              st    <= S_ERASE;
            end else begin
              err <= 1'b1;
            end
          end else if (wr_en && wp_ok) begin
            dac_val <= wr_data;
          end
        end
        S_ERASE: begin
          if (cnt == '0) st <= S_CHK_E;
          else           cnt <= cnt - 1'b1;
        end
        S_CHK_E: begin
          if (cell_rdata == ERASED) begin
            tries <= '0;
            cnt   <= CW'(WRITE_CYC - 1);
            st    <= S_WRITE;
          end else if (last_try) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            cnt   <= CW'(ERASE_CYC - 1);
            st    <= S_ERASE;
          end
        end
        S_WRITE: begin
          if (cnt == '0) st <= S_CHK_W;
          else           cnt <= cnt - 1'b1;
        end
        S_CHK_W: begin
          if (cell_rdata == tgt) begin
            st <= S_IDLE;
          end else if (last_try) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            cnt   <= CW'(WRITE_CYC - 1);
            st    <= S_WRITE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [BW-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_run <= '0;
    else if (busy)  busy_run <= busy_run + 1'b1;
    else            busy_run <= '0;
  end

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_erase && cell_write));

  // R9
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_erase || cell_write) |-> busy);

  // R10
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BW'(BUDGET_CYC)));

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dac_val));

  // R4
  sup_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !busy && commit_req && wp_ok && !supply_ok) |=> (err && !busy));

  // R1
  recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  // R3
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !busy && !wp_ok) |=> (!busy && $stable(err)));
endmodule

// File: tb/nv_commit_seq_bench.sv
module nv_commit_seq_bench;
  localparam int ECYC = 16;
  localparam int WCYC = 16;
  localparam int BUDG = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, commit_req = 1'b0, wp_ok = 1'b1, supply_ok = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mem = 8'h5A;
  logic cell_erase, cell_write, busy, err, ready;
  logic [7:0] cell_wdata, dac_val;

  int n_run = 0, n_fail = 0;
  int e_fail = 0, w_fail = 0;
  int e_pulses = 0, w_pulses = 0, e_run = 0, w_run = 0, bad_width = 0, busy_cyc = 0;
  logic e_prev = 1'b0, w_prev = 1'b0;
  logic [7:0] wd = 8'h00;
  logic saw_dropped = 1'b0;
  logic [7:0] dropped = 8'h00;

  always #2 clk = ~clk;

  nv_commit_seq #(.W(8), .ERASE_CYC(ECYC), .WRITE_CYC(WCYC), .MAX_TRIES(4), .BUDGET_CYC(BUDG))
  u_nv_commit_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .commit_req(commit_req),
    .wp_ok(wp_ok), .supply_ok(supply_ok), .cell_rdata(mem), .cell_erase(cell_erase),
    .cell_write(cell_write), .cell_wdata(cell_wdata), .dac_val(dac_val), .busy(busy),
    .err(err), .ready(ready));

  always @(negedge clk) begin
    if (cell_erase) begin
      if (!e_prev) e_pulses++;
      e_run++;
    end else if (e_prev) begin
      if (e_run != ECYC) bad_width++;
      e_run = 0;
      if (e_fail > 0) e_fail--; else mem = 8'hFF;
    end
    e_prev = cell_erase;
    if (cell_write) begin
      if (!w_prev) begin w_pulses++; wd = cell_wdata; end
      if (cell_wdata == dropped) saw_dropped = 1'b1;
      w_run++;
    end else if (w_prev) begin
      if (w_run != WCYC) bad_width++;
      w_run = 0;
      if (w_fail > 0) w_fail--; else mem = mem & wd;
    end
    w_prev = cell_write;
    if (busy) busy_cyc++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    e_pulses = 0; w_pulses = 0; bad_width = 0; busy_cyc = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic commit(input logic wp, input logic sup);
    clear_mon();
    @(negedge clk);
    commit_req = 1'b1; wp_ok = wp; supply_ok = sup;
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  task automatic set_val(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; wp_ok = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_recall(input logic [7:0] stored);
    mem = stored;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ready low before first edge", ready, 0);
    @(negedge clk);
    chk("R1 recalled value", dac_val, stored);
    chk("R1 ready high", ready, 1);
    chk("R1 busy low", busy, 0);
  endtask

  task automatic t_volatile_write();
    set_val(8'h3C);
    chk("R2 write accepted", dac_val, 8'h3C);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC3; wp_ok = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 write blocked by wp", dac_val, 8'h3C);
    wp_ok = 1'b1;
  endtask

  task automatic t_wp_block();
    logic [7:0] m0 = mem;
    logic e0 = err;
    commit(1'b0, 1'b1);
    chk("R3 busy stays low", busy, 0);
    repeat (ECYC + 4) @(negedge clk);
    chk("R3 no erase pulse", e_pulses, 0);
    chk("R3 err unchanged", err, e0);
    chk("R3 cell unchanged", mem, m0);
    wp_ok = 1'b1;
  endtask

  task automatic t_supply_low();
    commit(1'b1, 1'b0);
    chk("R4 err set", err, 1);
    chk("R4 busy low", busy, 0);
    repeat (ECYC + 4) @(negedge clk);
    chk("R4 no erase pulse", e_pulses, 0);
    supply_ok = 1'b1;
  endtask

  task automatic t_commit_ok();
    set_val(8'hA7);
    commit(1'b1, 1'b1);
    chk("R5 busy high after accept", busy, 1);
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h11; commit_req = 1'b1; wp_ok = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; commit_req = 1'b0;
    wait_idle();
    wp_ok = 1'b1;
    chk("R5 completes despite wp low", mem, 8'hA7);
    chk("R5 dac held", dac_val, 8'hA7);
    chk("R6 one erase pulse", e_pulses, 1);
    chk("R7 one write pulse", w_pulses, 1);
    chk("R6 R7 pulse widths", bad_width, 0);
    chk("R12 err cleared", err, 0);
    chk("R10 busy cycles", busy_cyc, (ECYC + 1) + (WCYC + 1));
    repeat (ECYC + 4) @(negedge clk);
    chk("R5 busy-time request ignored", e_pulses, 1);
  endtask

  task automatic t_erase_retry();
    set_val(8'h0F);
    e_fail = 2;
    commit(1'b1, 1'b1);
    wait_idle();
    chk("R6 three erase pulses", e_pulses, 3);
    chk("R6 stored after retry", mem, 8'h0F);
    chk("R6 err low", err, 0);
  endtask

  task automatic t_erase_exhaust();
    set_val(8'h42);
    e_fail = 4;
    commit(1'b1, 1'b1);
    wait_idle();
    chk("R8 four erase pulses", e_pulses, 4);
    chk("R8 no write pulse", w_pulses, 0);
    chk("R8 err set", err, 1);
    chk("R8 busy low", busy, 0);
    chk("R10 worst erase time", (busy_cyc <= BUDG) ? 1 : 0, 1);
    e_fail = 0;
  endtask

  task automatic t_write_retry();
    set_val(8'h96);
    w_fail = 3;
    commit(1'b1, 1'b1);
    wait_idle();
    chk("R7 four write pulses", w_pulses, 4);
    chk("R7 stored on last try", mem, 8'h96);
    chk("R12 err low after success", err, 0);
  endtask

  task automatic t_write_exhaust();
    set_val(8'h24);
    e_fail = 3; w_fail = 4;
    commit(1'b1, 1'b1);
    wait_idle();
    chk("R8 write exhaust pulses", w_pulses, 4);
    chk("R8 write exhaust err", err, 1);
    chk("R8 cell left erased", mem, 8'hFF);
    chk("R10 worst case within budget", (busy_cyc <= BUDG) ? 1 : 0, 1);
    repeat (WCYC + 4) @(negedge clk);
    chk("R8 no pulse after failure", w_pulses, 4);
    w_fail = 0;
  endtask

  task automatic t_same_cycle();
    set_val(8'h5C);
    dropped = 8'hE1; saw_dropped = 1'b0;
    clear_mon();
    @(negedge clk);
    commit_req = 1'b1; wr_en = 1'b1; wr_data = 8'hE1; wp_ok = 1'b1; supply_ok = 1'b1;
    @(negedge clk);
    commit_req = 1'b0; wr_en = 1'b0;
    wait_idle();
    chk("R11 committed old value", mem, 8'h5C);
    chk("R11 write dropped", dac_val, 8'h5C);
    chk("R11 dropped value never written", saw_dropped, 0);
    dropped = 8'h00;
  endtask

  initial begin
    t_reset_recall(8'h5A);
    t_volatile_write();
    t_wp_block();
    t_supply_low();
    t_commit_ok();
    t_erase_retry();
    t_erase_exhaust();
    t_write_retry();
    t_write_exhaust();
    t_same_cycle();
    t_reset_recall(mem);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule